// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block runs a 10-bit successive-approximation conversion for an analog front end outside it. Software sets a control register to pick one of eight input channels, a per-bit period and the enable, and then sets a start bit. The block drives the channel select to the analog multiplexer and a trial code to the DAC. It reads one comparator bit at the end of each bit period and settles the result from the most significant bit to the least significant bit.

A conversion lasts thirteen bit periods. The first two periods are for settling and acquisition, the next ten each resolve one bit, and a final period holds the finished code. On completion the hardware clears the start bit and places the result into two byte registers, justified left or right as a format bit chooses. It also raises a sticky interrupt flag.

The per-bit period is the system clock divided by 2, 8 or 32. In the fourth setting, one period passes for each pulse on a separate slow-tick input.

Top module: `sar_seq_ctrl`

Register map (2-bit address): 0 = control, 1 = configuration, 2 = result high byte, 3 = result low byte. Control byte: bits 7:6 period select, bits 5:3 channel, bit 2 start/busy, bit 1 always reads 0, bit 0 enable. Configuration byte: bit 0 format (0 left, 1 right), bit 1 interrupt flag, other bits read 0. Result registers are read-only.

## Requirements
- R1: After reset every register reads 0, and the interrupt, channel select and trial code outputs are 0.
- R2: A control write starts a conversion only when it sets both bit 2 (start) and bit 0 (enable). With enable 0 nothing runs, and the busy bit, the result and the interrupt flag stay as they were. While busy, the enable bit reads 1.
- R3: The busy bit (control bit 2) reads 1 from the cycle after the starting write. Hardware clears it after exactly 13 bit periods, which is 13×N cycles with N = 2, 8 or 32 for period select 00, 01 or 10.
- R4: With period select 11, a period ends on each cycle in which the slow-tick input is high. The conversion ends on the 13th such pulse, and it does not advance while no pulses arrive.
- R5: The search is MSB first. Each trial code is the bits kept so far plus the bit under test. That bit is kept when the comparator reads 1. With a comparator that reports input ≥ trial code, the result equals the input code, from 0 through 1023.
- R6: With format 0, the high byte holds result bits 9:2, and the low byte holds bits 1:0 in its bits 7:6 with zeros below.
- R7: With format 1, the high byte holds result bits 9:8 in its bits 1:0 with zeros above, and the low byte holds bits 7:0.
- R8: Control bit 1 always reads 0, and the other control fields read back as written (bit 2 shows busy).
- R9: While idle, the channel select output follows the channel field. During a conversion it holds the channel latched at the start, even if the field is rewritten.
- R10: The interrupt flag sets on completion and stays set until a configuration write with bit 1 at 0. Writing 1 has no effect. A completion and a clearing write in the same cycle leave the flag set.
- R11: A control write during a conversion with start or enable at 0 aborts it. Busy clears on the next cycle, and the result registers and interrupt flag are unchanged. This holds even when the abort lands on the completing cycle.
- R12: The trial code output is 0 whenever no conversion is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| slow_tick | input | 1 | Period pulse used when period select is 11 |
| cmp_in | input | 1 | Comparator result, 1 = input at or above trial code |
| mux_sel | output | 3 | Analog channel select |
| dac_code | output | 10 | Trial code to the DAC |
| irq | output | 1 | Sticky completion interrupt flag |

## Verification
Two pairs of events can fall in the same cycle. The first is completion and a software clear of the interrupt flag: the bench times a configuration write so that it is captured on the exact edge that ends the conversion, and the flag must stay set. The second is completion and an abort: a control write with start at 0 is placed on that same edge, and the result registers must keep their old bytes with no interrupt. A behavioural model in the bench counts the remaining cycles or pulses itself and judges busy, flag and channel on every clock.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // register addresses
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_RHI  = 2'd2;
  localparam logic [1:0] ADDR_RLO  = 2'd3;

  // per-bit period source
  typedef enum logic [1:0] {
    PER_DIV_A = 2'b00,
    PER_DIV_B = 2'b01,
    PER_DIV_C = 2'b10,
    PER_SLOW  = 2'b11
  } per_sel_e;

  // place a right-aligned result of 'width' bits into a 16-bit pair
  function automatic logic [15:0] place_result(logic [15:0] value,
                                               int unsigned width,
                                               logic        right_just);
    if (right_just) return value;
    return value << (16 - width);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b,
                                       int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_period_gen.sv
module sar_period_gen
  import sar_pkg::*;
#(
  parameter int unsigned DIV_A = 2,
  parameter int unsigned DIV_B = 8,
  parameter int unsigned DIV_C = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  per_sel_e sel,
  input  logic     slow_tick,
  output logic     tick_o
);
  localparam int unsigned MAXD = max3(DIV_A, DIV_B, DIV_C);
  localparam int unsigned CW   = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  always_comb begin
    case (sel)
      PER_DIV_A: lim_m1 = CW'(DIV_A - 1);
      PER_DIV_B: lim_m1 = CW'(DIV_B - 1);
      PER_DIV_C: lim_m1 = CW'(DIV_C - 1);
      default:   lim_m1 = CW'(DIV_C - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (cnt == lim_m1)   cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign tick_o = run & ((sel == PER_SLOW) ? slow_tick : (cnt == lim_m1));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int unsigned RES  = 10,
  parameter int unsigned PRE  = 2,
  parameter int unsigned POST = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           run,
  input  logic           tick,
  input  logic           cmp,
  output logic [RES-1:0] code_o,
  output logic           done_o,
  output logic [RES-1:0] result_o
);
  localparam int unsigned TOTAL = PRE + RES + POST;
  localparam int unsigned LAST  = TOTAL - 1;
  localparam int unsigned PW    = $clog2(TOTAL);

  logic [PW-1:0]  phase;
  logic [RES-1:0] acc;
  logic [RES-1:0] trial;

  // one-hot bit under test for the current phase, MSB first
  always_comb begin
    for (int i = 0; i < RES; i++) begin
      trial[i] = (int'(phase) == int'(PRE + RES - 1) - i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      acc   <= '0;
    end else if (start) begin
      phase <= '0;
      acc   <= '0;
    end else if (run && tick) begin
      phase <= phase + 1'b1;
      if (cmp) acc <= acc | trial;
    end
  end

  assign code_o   = run ? (acc | trial) : '0;
  assign done_o   = run && tick && (phase == PW'(LAST));
  assign result_o = acc;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_BITS     = 10,
  parameter int unsigned DIV_A        = 2,
  parameter int unsigned DIV_B        = 8,
  parameter int unsigned DIV_C        = 32,
  parameter int unsigned PRE_PERIODS  = 2,
  parameter int unsigned POST_PERIODS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                slow_tick,
  input  logic                cmp_in,
  output logic [2:0]          mux_sel,
  output logic [RES_BITS-1:0] dac_code,
  output logic                irq
);
  localparam int unsigned CHW = 3;

  // control fields
  logic           en_r;
  logic [CHW-1:0] ch_r;
  per_sel_e       per_r;
  logic           busy_r;
  logic [CHW-1:0] ch_lat;
  per_sel_e       per_lat;
  // configuration and results
  logic           fmt_r;
  logic           irq_r;
  logic [7:0]     res_hi;
  logic [7:0]     res_lo;

  // named events
  logic wr_ctrl, wr_cfg;
  logic start_evt, abort_evt, done_evt, done_commit, irq_clr;
  logic tick;
  logic [RES_BITS-1:0] result;
  logic [15:0]         placed;

  assign wr_ctrl     = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_cfg      = reg_wr && (reg_addr == ADDR_CFG);
  assign start_evt   = wr_ctrl && !busy_r && reg_wdata[2] && reg_wdata[0];
  assign abort_evt   = wr_ctrl && busy_r && !(reg_wdata[2] && reg_wdata[0]);
  assign done_commit = done_evt && !abort_evt;
  assign irq_clr     = wr_cfg && !reg_wdata[1];

  sar_period_gen #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_r),
    .sel      (per_lat),
    .slow_tick(slow_tick),
    .tick_o   (tick)
  );

  sar_search #(
    .RES(RES_BITS), .PRE(PRE_PERIODS), .POST(POST_PERIODS)
  ) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_evt),
    .run     (busy_r),
    .tick    (tick),
    .cmp     (cmp_in),
    .code_o  (dac_code),
    .done_o  (done_evt),
    .result_o(result)
  );

  assign placed = place_result(16'(result), RES_BITS, fmt_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_r    <= 1'b0;
      ch_r    <= '0;
      per_r   <= PER_DIV_A;
      busy_r  <= 1'b0;
      ch_lat  <= '0;
      per_lat <= PER_DIV_A;
      fmt_r   <= 1'b0;
      irq_r   <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_r  <= reg_wdata[0];
        ch_r  <= reg_wdata[5:3];
        per_r <= per_sel_e'(reg_wdata[7:6]);
      end
      if (start_evt) begin
        busy_r  <= 1'b1;
        ch_lat  <= reg_wdata[5:3];
        per_lat <= per_sel_e'(reg_wdata[7:6]);
      end else if (abort_evt || done_commit) begin
        busy_r  <= 1'b0;
      end
      if (wr_cfg) fmt_r <= reg_wdata[0];
      if (done_commit)  irq_r <= 1'b1;
      else if (irq_clr) irq_r <= 1'b0;
      if (done_commit) begin
        res_hi <= placed[15:8];
        res_lo <= placed[7:0];
      end
    end
  end

  assign mux_sel = busy_r ? ch_lat : ch_r;
  assign irq     = irq_r;

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {per_r, ch_r, busy_r, 1'b0, en_r};
      ADDR_CFG:  reg_rdata = {6'b0, irq_r, fmt_r};
      ADDR_RHI:  reg_rdata = res_hi;
      default:   reg_rdata = res_lo;
    endcase
  end

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int unsigned RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                en,
  input logic                start_evt,
  input logic                abort_evt,
  input logic                done_evt,
  input logic                irq_clr,
  input logic                irq,
  input logic [RES_BITS-1:0] dac_code,
  input logic [2:0]          mux_sel,
  input logic [7:0]          res_hi,
  input logic [7:0]          res_lo
);

  assert_busy_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> en);

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !abort_evt) |=> !busy);

  assert_chan_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort_evt && !done_evt) |=> $stable(mux_sel));

  assert_done_sets_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !abort_evt) |=> irq);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_abort_keeps_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && $stable(res_hi) && $stable(res_lo)));

  assert_idle_code_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_code == '0));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_r),
  .en       (en_r),
  .start_evt(start_evt),
  .abort_evt(abort_evt),
  .done_evt (done_evt),
  .irq_clr  (irq_clr),
  .irq      (irq),
  .dac_code (dac_code),
  .mux_sel  (mux_sel),
  .res_hi   (res_hi),
  .res_lo   (res_lo)
);

// File: tb/tb_sar_seq_ctrl.sv
`timescale 1ns/1ps
module tb_sar_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       slow_tick = 1'b0;
  logic       cmp_in;
  logic [2:0] mux_sel;
  logic [9:0] dac_code;
  logic       irq;

  int vin = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit slow_on = 1'b0;

  always #4 clk = ~clk;

  assign cmp_in = (vin >= int'(dac_code));

  sar_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slow_tick(slow_tick),
    .cmp_in(cmp_in), .mux_sel(mux_sel), .dac_code(dac_code), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_en, m_busy, m_fmt, m_irq;
  int       m_ch, m_per, m_chl, m_perl, m_hi, m_lo, m_left;

  function automatic int period_cycles(input int sel);
    if (sel == 0) return 2;
    if (sel == 1) return 8;
    return 32;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_fmt = 0; m_irq = 0;
      m_ch = 0; m_per = 0; m_chl = 0; m_perl = 0; m_hi = 0; m_lo = 0; m_left = 0;
    end else begin
      bit wc, wf, st, ab, fin;
      wc  = reg_wr && reg_addr == 2'd0;
      wf  = reg_wr && reg_addr == 2'd1;
      st  = wc && !m_busy && reg_wdata[2] && reg_wdata[0];
      ab  = wc && m_busy && !(reg_wdata[2] && reg_wdata[0]);
      fin = 0;
      if (m_busy && !ab) begin
        if (m_perl != 3 || slow_tick) m_left--;
        if (m_left == 0) fin = 1;
      end
      if (fin) begin
        m_busy = 0;
        m_irq  = 1;
        if (m_fmt) begin m_hi = vin / 256; m_lo = vin % 256; end
        else       begin m_hi = vin / 4;   m_lo = (vin % 4) * 64; end
      end else if (wf && !reg_wdata[1]) m_irq = 0;
      if (ab) m_busy = 0;
      if (st) begin
        m_busy = 1;
        m_chl  = int'(reg_wdata[5:3]);
        m_perl = int'(reg_wdata[7:6]);
        m_left = (m_perl == 3) ? 13 : 13 * period_cycles(m_perl);
      end
      if (wc) begin
        m_en = reg_wdata[0]; m_ch = int'(reg_wdata[5:3]); m_per = int'(reg_wdata[7:6]);
      end
      if (wf) m_fmt = reg_wdata[0];
      #1;
      begin
        int exp_ctrl;
        exp_ctrl = m_per * 64 + m_ch * 8 + (m_busy ? 4 : 0) + (m_en ? 1 : 0);
        check(int'(irq) == int'(m_irq), "R10 irq flag", int'(irq), int'(m_irq));
        check(int'(mux_sel) == (m_busy ? m_chl : m_ch), "R9 channel select",
              int'(mux_sel), m_busy ? m_chl : m_ch);
        if (reg_addr == 2'd0)
          check(int'(reg_rdata) == exp_ctrl, "R3 control/busy readback",
                int'(reg_rdata), exp_ctrl);
        if (!m_busy)
          check(dac_code == 10'd0, "R12 idle trial code", int'(dac_code), 0);
      end
    end
  end

  // slow-tick source: one pulse every 5 cycles when on
  always @(negedge clk) begin
    int ph;
    ph = ($time / 8) % 5;
    slow_tick <= slow_on && (ph == 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
    reg_addr = 2'd0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    do begin
      @(posedge clk); #2;
      n++;
    end while (reg_rdata[2] && n < 20000);
  endtask

  task automatic run_conv(input int sel, input int ch, input int fmt, input int value,
                          input string req);
    int n, hi, lo, ehi, elo;
    vin = value;
    wr(2'd1, 8'(fmt));
    wr(2'd0, 8'(sel * 64 + ch * 8 + 5));
    wait_idle(n);
    if (sel != 3)
      check(n == 13 * period_cycles(sel), "R3 conversion length", n, 13 * period_cycles(sel));
    rd(2'd2, hi);
    rd(2'd3, lo);
    if (fmt == 0) begin ehi = (value >> 2) & 8'hFF; elo = (value & 3) << 6; end
    else          begin ehi = (value >> 8) & 3;     elo = value & 8'hFF; end
    check(hi == ehi, {req, " result high byte"}, hi, ehi);
    check(lo == elo, {req, " result low byte"}, lo, elo);
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1 register reset value", v, 0);
    end
    check(irq == 1'b0 && mux_sel == 3'd0 && dac_code == 10'd0, "R1 outputs at reset",
          int'({irq, mux_sel, dac_code}), 0);

    // R2 start without enable does nothing
    vin = 300;
    wr(2'd0, 8'h04);
    repeat (60) @(negedge clk);
    rd(2'd0, v);
    check(v == 0, "R2 no start when disabled", v, 0);
    rd(2'd2, v);
    check(v == 0, "R2 result untouched", v, 0);

    // R5/R6/R7 conversions at several periods, values and formats
    run_conv(0, 5, 0, 'h2B7, "R5 R6 div2");
    run_conv(1, 2, 1, 'h3FF, "R5 R7 div8 full scale");
    run_conv(2, 0, 0, 0,     "R5 R6 div32 zero");
    run_conv(0, 3, 1, 'h155, "R5 R7 div2");
    run_conv(0, 1, 0, 'h001, "R5 R6 lsb only");

    // R4 slow-tick periods, including a stall with no pulses
    slow_on = 1'b1;
    vin = 'h200;
    wr(2'd0, 8'hC5);
    repeat (20) @(negedge clk);
    slow_on = 1'b0;
    repeat (50) @(negedge clk);
    rd(2'd0, v);
    check(v[2] == 1'b1, "R4 stalls without slow ticks", v[2], 1);
    slow_on = 1'b1;
    wait_idle(n);
    slow_on = 1'b0;
    rd(2'd2, v);
    check(v == 'h80, "R4 slow-tick result high", v, 'h80);

    // R8 bit 1 reads 0, fields read back
    wr(2'd0, 8'hFB);
    rd(2'd0, v);
    check(v == 'hF9, "R8 control readback", v, 'hF9);

    // R9 channel held during conversion
    vin = 'h0AA;
    wr(2'd0, 8'h80 | (6 << 3) | 5);
    repeat (30) @(negedge clk);
    wr(2'd0, 8'h80 | (1 << 3) | 5);
    #1 check(mux_sel == 3'd6, "R9 latched channel", int'(mux_sel), 6);
    wait_idle(n);
    #1 check(mux_sel == 3'd1, "R9 channel follows field when idle", int'(mux_sel), 1);

    // R11 abort mid-conversion
    wr(2'd1, 8'h00);   // clear irq, left format
    vin = 'h3C3;
    wr(2'd0, 8'h45);   // div8
    repeat (40) @(negedge clk);
    wr(2'd0, 8'h41);   // start 0 -> abort
    rd(2'd0, v);
    check(v[2] == 1'b0, "R11 abort clears busy", v[2], 0);
    rd(2'd2, v);
    check(v == ('h0AA >> 2), "R11 result kept after abort", v, 'h0AA >> 2);
    check(irq == 1'b0, "R11 no interrupt after abort", int'(irq), 0);

    // R11 abort on the completing edge (div2, completes at edge 26)
    wr(2'd0, 8'h05);
    repeat (25) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    rd(2'd2, v);
    check(v == ('h0AA >> 2), "R11 abort wins over completion", v, 'h0AA >> 2);
    check(irq == 1'b0, "R11 no interrupt on aborted completion", int'(irq), 0);

    // R10 set wins over clear on the same edge
    vin = 'h111;
    wr(2'd0, 8'h05);
    wait_idle(n);
    check(irq == 1'b1, "R10 irq set on completion", int'(irq), 1);
    wr(2'd0, 8'h05);
    repeat (25) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
    check(irq == 1'b1, "R10 set wins over clear", int'(irq), 1);
    wr(2'd1, 8'h02);
    check(irq == 1'b1, "R10 writing 1 keeps flag", int'(irq), 1);
    wr(2'd1, 8'h00);
    check(irq == 1'b0, "R10 writing 0 clears flag", int'(irq), 0);
    wr(2'd1, 8'h02);
    check(irq == 1'b0, "R10 writing 1 does not set", int'(irq), 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule